// File: doc/BRIEF.md
# Dual-Address I2C Register and Memory Slave

This block is an I2C target that responds to two 7-bit bus addresses. One address opens a control register window at offsets 00h to 2Fh. The registers themselves live outside the block and are reached through a small internal bus: an address, a write strobe with write data, and a read-data return. The other address opens a 128-byte scratch memory held inside the block. Because the two spaces use different addresses, one transaction never reaches both.

A write transaction carries a word pointer after the address byte. The data bytes that follow land at that pointer and at the addresses after it. A repeated START followed by a read address byte turns the transfer into a read from the pointer. The read continues byte by byte until the master answers with a NACK.

Writes to the clock offsets 00h to 06h are let through only while an unlock level is high. That level is bit 6 of control register 08h, which the external register file supplies. At the start of every read of the register space, the block emits a one-cycle load strobe. The register file uses it to capture all clock fields into a stable copy for the duration of the read. While the device runs on backup power, the bus is ignored completely.

Top module: `i2c_regmem_slave`

## Requirements
- R1: The address byte 1101111 (register space) and the address byte 1010111 (memory space) are acknowledged by pulling SDA low in the ninth clock. Any other address is not acknowledged: sda_oe stays 0.
- R2: In a write transaction, the first byte after the address byte sets the word pointer. Each following data byte is acknowledged and written at the pointer, and the pointer then advances by one (page write).
- R3: A register write to offsets 00h to 06h is issued on the internal bus only if clk_wr_unlock is 1 when the byte completes. Offsets 07h to 2Fh are written unconditionally.
- R4: Register offsets above 2Fh are still acknowledged. Writes to them produce no reg_wr, and reads from them return 00h.
- R5: The memory address is 7 bits wide and wraps from 7Fh to 00h, for both writes and reads.
- R6: A repeated START after the word pointer, followed by a read address byte, returns the byte at the pointer, then the bytes at the following addresses while the master acknowledges. A master NACK ends the read, and sda_oe returns to 0.
- R7: snap_load pulses for exactly one cycle when a read address byte for the register space is acknowledged. It never pulses for memory reads or for writes.
- R8: While on_backup is 1, the block does not acknowledge, does not write, does not pulse snap_load, and holds sda_oe at 0 from the next cycle on.
- R9: reg_wr is a single-cycle pulse. reg_addr and reg_wdata hold the target offset and the data in the same cycle.
- R10: After reset, sda_oe, reg_wr and snap_load are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| on_backup | input | 1 | High while running on backup power; bus disabled |
| clk_wr_unlock | input | 1 | Write-enable for clock offsets 00h-06h (register 08h bit 6) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_addr | output | 6 | Register offset for reads and writes |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for reg_addr |
| snap_load | output | 1 | One-cycle strobe to latch the clock fields |

## Verification
The bound checker watches every cycle for the following: a write to a clock offset without the unlock bit having been set one cycle before, a write outside 00h-2Fh, a strobe that lasts more than one cycle, and any bus activity in the cycle after backup power is flagged. Only the bench's scenarios can show the rest, because those properties span whole transfers. That covers address decoding with acknowledge, page writes landing at consecutive offsets, the memory wrap at 7Fh, reads through a repeated START returning the right byte sequence, 00h from unmapped offsets, and the single snapshot strobe for each register read.

// File: rtl/i2c_regmem_slave.sv
module i2c_regmem_slave #(
  parameter logic [6:0] REG_SLAVE = 7'h6F,
  parameter logic [6:0] MEM_SLAVE = 7'h57,
  parameter logic [7:0] REG_TOP   = 8'h2F,
  parameter logic [7:0] LOCK_TOP  = 8'h06,
  parameter int         MEM_DEPTH = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       on_backup,
  input  logic       clk_wr_unlock,
  output logic       sda_oe,
  output logic       reg_wr,
  output logic [5:0] reg_addr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata,
  output logic       snap_load
);
  localparam int MEM_AW = $clog2(MEM_DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WORD, S_WDATA, S_ACK, S_RDATA, S_RACK} state_t;

  logic [1:0] scl_s, sda_s;
  logic       scl_q, sda_q;
  state_t     state, ack_to;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txsh, ptr;
  logic       is_mem, mack, inc_pend;
  logic              mem_we;
  logic [MEM_AW-1:0] mem_wa;
  logic [7:0]        mem_wd;
  logic [7:0]        mem [MEM_DEPTH];

  wire scl_r = scl_s[1];
  wire sda_r = sda_s[1];
  wire start = scl_r & scl_q & sda_q & ~sda_r;
  wire stop  = scl_r & scl_q & ~sda_q & sda_r;
  wire rise  = scl_r & ~scl_q;
  wire fall  = ~scl_r & scl_q;

  logic [MEM_AW-1:0] mem_inc;
  logic [7:0]        ptr_nxt, rd_byte;
  logic              wr_ok, hit_reg, hit_mem;

  assign mem_inc  = ptr[MEM_AW-1:0] + 1'b1;
  assign ptr_nxt  = is_mem ? {{(8-MEM_AW){1'b0}}, mem_inc} : ptr + 8'd1;
  assign rd_byte  = is_mem ? mem[ptr[MEM_AW-1:0]] : ((ptr <= REG_TOP) ? reg_rdata : 8'h00);
  assign wr_ok    = (ptr <= REG_TOP) && ((ptr > LOCK_TOP) || clk_wr_unlock);
  assign hit_reg  = shreg[7:1] == REG_SLAVE;
  assign hit_mem  = shreg[7:1] == MEM_SLAVE;
  assign reg_addr = ptr[5:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11; sda_s <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i}; sda_s <= {sda_s[0], sda_i};
      scl_q <= scl_r; sda_q <= sda_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; ack_to <= S_IDLE; bitcnt <= '0;
      shreg <= '0; txsh <= '0; ptr <= '0;
      is_mem <= 1'b0; mack <= 1'b0; inc_pend <= 1'b0;
      sda_oe <= 1'b0; reg_wr <= 1'b0; reg_wdata <= '0; snap_load <= 1'b0;
      mem_we <= 1'b0; mem_wa <= '0; mem_wd <= '0;
    end else begin
      reg_wr <= 1'b0; snap_load <= 1'b0; mem_we <= 1'b0;
      if (on_backup) begin
        state <= S_IDLE; sda_oe <= 1'b0;
      end else if (start) begin
        state <= S_ADDR; bitcnt <= '0; sda_oe <= 1'b0; inc_pend <= 1'b0;
      end else if (stop) begin
        state <= S_IDLE; sda_oe <= 1'b0;
      end else if (rise) begin
        case (state)
          S_ADDR, S_WORD, S_WDATA: begin
            shreg <= {shreg[6:0], sda_r}; bitcnt <= bitcnt + 4'd1;
          end
          S_RDATA: bitcnt <= bitcnt + 4'd1;
          S_RACK:  mack <= ~sda_r;
          default: ;
        endcase
      end else if (fall) begin
        case (state)
          S_ADDR: if (bitcnt == 4'd8) begin
            if (hit_reg || hit_mem) begin
              is_mem <= hit_mem; sda_oe <= 1'b1; state <= S_ACK;
              ack_to <= shreg[0] ? S_RDATA : S_WORD;
              snap_load <= shreg[0] & hit_reg;
            end else state <= S_IDLE;
          end
          S_WORD: if (bitcnt == 4'd8) begin
            ptr <= is_mem ? {1'b0, shreg[6:0]} : shreg;
            sda_oe <= 1'b1; state <= S_ACK; ack_to <= S_WDATA;
          end
          S_WDATA: if (bitcnt == 4'd8) begin
            if (is_mem) begin
              mem_we <= 1'b1; mem_wa <= ptr[MEM_AW-1:0]; mem_wd <= shreg;
            end else if (wr_ok) begin
              reg_wr <= 1'b1; reg_wdata <= shreg;
            end
            inc_pend <= 1'b1; sda_oe <= 1'b1; state <= S_ACK; ack_to <= S_WDATA;
          end
          S_ACK: begin
            bitcnt <= '0;
            if (ack_to == S_RDATA) begin
              txsh <= {rd_byte[6:0], 1'b0}; sda_oe <= ~rd_byte[7];
              ptr <= ptr_nxt; state <= S_RDATA;
            end else begin
              sda_oe <= 1'b0; state <= ack_to;
              if (inc_pend) ptr <= ptr_nxt;
              inc_pend <= 1'b0;
            end
          end
          S_RDATA: if (bitcnt == 4'd8) begin
            sda_oe <= 1'b0; state <= S_RACK;
          end else begin
            sda_oe <= ~txsh[7]; txsh <= {txsh[6:0], 1'b0};
          end
          S_RACK: if (mack) begin
            bitcnt <= '0; txsh <= {rd_byte[6:0], 1'b0}; sda_oe <= ~rd_byte[7];
            ptr <= ptr_nxt; state <= S_RDATA;
          end else state <= S_IDLE;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) if (mem_we) mem[mem_wa] <= mem_wd;
endmodule

module i2c_regmem_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       on_backup,
  input logic       clk_wr_unlock,
  input logic       sda_oe,
  input logic       reg_wr,
  input logic [5:0] reg_addr,
  input logic       snap_load
);
  AST_CLOCK_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr <= 6'h06) |-> $past(clk_wr_unlock)); // R3
  AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> reg_addr <= 6'h2F); // R4
  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr); // R9
  AST_SNAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_load |=> !snap_load); // R7
  AST_BACKUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    on_backup |=> !sda_oe && !reg_wr && !snap_load); // R8
endmodule

bind i2c_regmem_slave i2c_regmem_slave_chk chk (.*);

// File: tb/i2c_regmem_slave_test.sv
module i2c_regmem_slave_test;
  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1, on_backup = 0;
  logic sda_oe, reg_wr, snap_load;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] rf [64];
  logic [7:0] exp_rf [64];
  logic [13:0] wq[$];
  int checks = 0, failures = 0, snap_seen = 0, snap_exp = 0;
  wire sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_regmem_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .on_backup(on_backup), .clk_wr_unlock(rf[8][6]), .sda_oe(sda_oe),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .snap_load(snap_load));

  assign reg_rdata = rf[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < 64; i++) rf[i] <= (i == 8) ? 8'h00 : 8'(8'h80 + i);
    else if (reg_wr) rf[reg_addr] <= reg_wdata;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock reference: every write strobe must match the next queued expectation.
  always @(negedge clk) if (rst_n) begin
    if (snap_load) snap_seen++;
    if (reg_wr) begin
      if (wq.size() == 0) chk(0, "R3 unexpected reg_wr", {reg_addr, reg_wdata}, 0);
      else begin
        logic [13:0] e;
        e = wq.pop_front();
        chk({reg_addr, reg_wdata} == e, "R9 reg_wr addr/data", {reg_addr, reg_wdata}, e);
      end
    end
  end

  task automatic q(); repeat (10) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q();
  endtask

  task automatic i2c_stop();
    sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q();
  endtask

  task automatic wb(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1; q(); q(); scl_m = 0; q();
    end
    sda_m = 1; q(); scl_m = 1; q(); ack = !sda_bus; q(); scl_m = 0; q();
  endtask

  task automatic rb(output logic [7:0] b, input bit ack);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1; q(); b[i] = sda_bus; q(); scl_m = 0;
    end
    q(); sda_m = ack ? 1'b0 : 1'b1; q(); scl_m = 1; q(); q(); scl_m = 0; q(); sda_m = 1;
  endtask

  task automatic exp_wr(input logic [5:0] a, input logic [7:0] d);
    wq.push_back({a, d}); exp_rf[a] = d;
  endtask

  task automatic reg_read_setup(input logic [7:0] ptr);
    bit a;
    i2c_start(); wb(8'hDE, a); wb(ptr, a);
    i2c_start(); wb(8'hDF, a); snap_exp++;
    chk(a, "R1 register read address ack", a, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] d;
    for (int i = 0; i < 64; i++) exp_rf[i] = (i == 8) ? 8'h00 : 8'(8'h80 + i);
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!sda_oe && !reg_wr && !snap_load, "R10 reset outputs", {sda_oe, reg_wr, snap_load}, 0);

    // R1/R2: page write into the register space from offset 07h
    i2c_start(); wb(8'hDE, a);
    chk(a, "R1 register write address ack", a, 1);
    wb(8'h07, a);
    chk(a, "R2 word pointer ack", a, 1);
    exp_wr(6'h07, 8'hA1); wb(8'hA1, a);
    exp_wr(6'h08, 8'h00); wb(8'h00, a);
    chk(a, "R2 data byte ack", a, 1);
    i2c_stop(); q();
    chk(wq.size() == 0, "R2 page write all issued", wq.size(), 0);

    // R3: clock offset locked
    i2c_start(); wb(8'hDE, a); wb(8'h02, a); wb(8'h5A, a);
    chk(a, "R3 locked write still acked", a, 1);
    i2c_stop(); q();
    reg_read_setup(8'h02); rb(d, 0); i2c_stop();
    chk(d == exp_rf[2], "R3 locked offset unchanged", d, exp_rf[2]);

    // R3: unlock then write clock offsets 05h..06h, read back
    i2c_start(); wb(8'hDE, a); wb(8'h08, a); exp_wr(6'h08, 8'h40); wb(8'h40, a); i2c_stop(); q();
    i2c_start(); wb(8'hDE, a); wb(8'h05, a);
    exp_wr(6'h05, 8'h55); wb(8'h55, a);
    exp_wr(6'h06, 8'h66); wb(8'h66, a);
    i2c_stop(); q();
    chk(wq.size() == 0, "R3 unlocked writes issued", wq.size(), 0);
    reg_read_setup(8'h05);
    rb(d, 1); chk(d == 8'h55, "R6 sequential read byte 0", d, 8'h55);
    rb(d, 0); chk(d == 8'h66, "R6 sequential read byte 1", d, 8'h66);
    i2c_stop(); q();
    chk(!sda_oe, "R6 sda released after NACK", sda_oe, 0);

    // R4: top of window and beyond
    i2c_start(); wb(8'hDE, a); wb(8'h2F, a);
    exp_wr(6'h2F, 8'h11); wb(8'h11, a);
    wb(8'h22, a);
    chk(a, "R4 out-of-window write acked", a, 1);
    i2c_stop(); q();
    reg_read_setup(8'h2E);
    rb(d, 1); chk(d == exp_rf[6'h2E], "R6 read at 2Eh", d, exp_rf[6'h2E]);
    rb(d, 1); chk(d == 8'h11, "R4 read at 2Fh", d, 8'h11);
    rb(d, 0); chk(d == 8'h00, "R4 read above 2Fh is zero", d, 8'h00);
    i2c_stop(); q();
    chk(snap_seen == snap_exp, "R7 one snapshot per register read", snap_seen, snap_exp);

    // R5: memory wrap
    i2c_start(); wb(8'hAE, a);
    chk(a, "R1 memory address ack", a, 1);
    wb(8'h7E, a); wb(8'hC1, a); wb(8'hC2, a); wb(8'hC3, a);
    i2c_stop(); q();
    i2c_start(); wb(8'hAE, a); wb(8'h7F, a); i2c_start(); wb(8'hAF, a);
    rb(d, 1); chk(d == 8'hC2, "R5 memory read at 7Fh", d, 8'hC2);
    rb(d, 0); chk(d == 8'hC3, "R5 memory wrap to 00h", d, 8'hC3);
    i2c_stop(); q();
    chk(snap_seen == snap_exp, "R7 no snapshot for memory read", snap_seen, snap_exp);

    // R1: foreign address
    i2c_start(); wb(8'hA0, a);
    chk(!a, "R1 foreign address not acked", a, 0);
    i2c_stop(); q();

    // R8: backup power
    on_backup = 1;
    i2c_start(); wb(8'hDE, a);
    chk(!a, "R8 no ack on backup", a, 0);
    wb(8'h07, a); wb(8'hEE, a);
    i2c_stop(); q();
    on_backup = 0; q();
    reg_read_setup(8'h07); rb(d, 0); i2c_stop(); q();
    chk(d == exp_rf[7], "R8 no write on backup", d, exp_rf[7]);

    chk(wq.size() == 0, "R9 no pending writes", wq.size(), 0);
    chk(snap_seen == snap_exp, "R7 snapshot count", snap_seen, snap_exp);
    summary();
    $finish;
  end
endmodule